// File: doc/BRIEF.md
# Descriptor-Chained Memory-to-Stream Engine

This block is the transmit-side engine of one DMA channel. It is started with the address of a data descriptor and the address of the context descriptor that owns the chain. It then walks the linked list of descriptors held in memory. Each descriptor is four 32-bit words at consecutive word addresses: offset 0 holds the next-descriptor pointer, offset 4 the buffer start, offset 8 a flags word, and offset 12 the "after" pointer, one past the last byte. For each descriptor the engine sends the bytes in `[buffer start, after)` to a byte stream sink over a valid/ready handshake. Progress is kept in a saved-buffer pointer that is compared against the after pointer. When that pointer reaches after, the engine writes the descriptor back. It then either follows the next pointer or, at the end of the list, marks the context descriptor disabled and stops.

The memory side is a word-wide master with one outstanding request. A request is held until a single-cycle acknowledge arrives, and read data comes with the acknowledge. Stream bytes are taken from a fetched word by byte lane, little-endian. One word is read per aligned word of the buffer. A single burst inside one descriptor is capped at `BURST_MAX` bytes. When the cap is reached first, the engine re-reads the descriptor and goes on from the saved-buffer pointer.

The controller moves through these states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting for a start. |
| `ST_LOAD` | Reading the four descriptor words. |
| `ST_CHECK` | Taking the buffer start when a new descriptor was loaded, then comparing the pointer with after. |
| `ST_FETCH` | Reading one buffer word. |
| `ST_STREAM` | Presenting bytes to the sink. |
| `ST_FINISH` | The descriptor is done; the interrupt pulse is raised here. |
| `ST_WBACK` | Writing the four descriptor words back. |
| `ST_CTX_RD` | Reading the context flags word. |
| `ST_CTX_WR` | Writing the context flags word with the disable bit set. |

The transitions are:

- IDLE→LOAD on start.
- LOAD→CHECK after the fourth word.
- CHECK→FINISH when the descriptor is empty, otherwise CHECK→FETCH.
- FETCH→STREAM on acknowledge.
- From STREAM, on each accepted byte:
  - STREAM→FINISH on the last byte.
  - STREAM→LOAD at the burst cap.
  - STREAM→FETCH at a word boundary.
- FINISH→WBACK.
- WBACK→LOAD after the fourth word when the end-of-list bit is clear.
- WBACK→CTX_RD after the fourth word when the end-of-list bit is set.
- CTX_RD→CTX_WR on acknowledge.
- CTX_WR→IDLE on acknowledge.

Top module: `m2s_dma_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `eol_o`, `irq_set_o`, `st_valid_o` and `mem_req_o` are all 0.
- R2: A start pulse seen while idle clears the end-of-list flag, raises `busy_o` and reads the four descriptor words from the given pointer. A start pulse seen while busy is ignored.
- R3: The bytes of `[buffer start, after)` appear on `st_data_o` in ascending address order. The byte at address a is lane (a mod 4) of the word at a with its two low bits cleared, where lane 0 is bits 7:0.
- R4: While `st_valid_o` is high and `st_ready_i` is low, the next cycle keeps `st_valid_o` high with `st_data_o` and `st_last_o` unchanged.
- R5: `st_last_o` is high on the final byte of a descriptor exactly when bit 3 of its flags word is set. No byte follows it in the next cycle.
- R6: A descriptor whose buffer start equals its after pointer sends no bytes but still completes: interrupt, write-back and chaining all take place.
- R7: After `BURST_MAX` bytes of one descriptor have been accepted without reaching after, the descriptor is re-read from memory. Streaming resumes at the next byte, so a descriptor of length L>0 is read ceil(L/`BURST_MAX`) times.
- R8: When a descriptor completes with bit 4 of its flags set, `irq_set_o` pulses for one cycle. The pulse comes after its last byte and is followed at once by the write-back.
- R9: A completed descriptor is written back as four words to its own four addresses before any later descriptor or context access.
- R10: If bit 0 (end of list) of the flags is clear, the next pointer becomes the descriptor pointer. The new descriptor is loaded and the saved-buffer pointer takes its buffer start.
- R11: If bit 0 of the flags is set, the context flags word at context pointer + 4 is read and rewritten with bit 15 set. `eol_o` then rises and the engine returns to idle.
- R12: While `eol_o` is set and no start arrives, the engine makes no memory request and presents no byte.
- R13: A memory request holds its address, direction and write data until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| desc_ptr_i | input | ADDR_W | Address of the first data descriptor |
| ctx_ptr_i | input | ADDR_W | Address of the owning context descriptor |
| busy_o | output | 1 | Engine is not idle |
| eol_o | output | 1 | Channel end-of-list flag |
| irq_set_o | output | 1 | One-cycle pulse that sets raw interrupt bit 2 |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | ADDR_W | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | One-cycle request acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| st_valid_o | output | 1 | Stream byte valid |
| st_ready_i | input | 1 | Sink ready |
| st_data_o | output | 8 | Stream byte |
| st_last_o | output | 1 | End of packet on this byte |

## Verification
The bench builds the engine with `ADDR_W` = 16 and `BURST_MAX` = 8. The small cap makes burst re-reads occur within a 20-byte descriptor, and an 8-byte descriptor probes the case where the cap and the buffer end coincide. A behavioural model turns the descriptor chain into a queue of expected bytes and interrupt events and compares it against the stream on every clock. This runs under random sink backpressure and random memory latency, with an unaligned buffer start, an empty descriptor and a stray start pulse issued mid-run. Write-backs, the context disable write and the number of descriptor reads are checked against counts computed from the chain.

// File: rtl/m2s_dma_pkg.sv
package m2s_dma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CHECK,
        ST_FETCH,
        ST_STREAM,
        ST_FINISH,
        ST_WBACK,
        ST_CTX_RD,
        ST_CTX_WR
    } m2s_state_e;

    // descriptor word slots
    localparam int DESC_WORDS = 4;
    localparam int W_NEXT     = 0;
    localparam int W_BUF      = 1;
    localparam int W_FLAGS    = 2;
    localparam int W_AFTER    = 3;

    // flag bit positions (data descriptor / context descriptor)
    localparam int FLG_EOL    = 0;
    localparam int FLG_OEOP   = 3;
    localparam int FLG_IRQ    = 4;
    localparam int CTX_DIS    = 15;

endpackage

// File: rtl/m2s_desc_regs.sv
module m2s_desc_regs #(
    parameter int NWORDS = 4,
    localparam int IW = $clog2(NWORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [IW-1:0]        wr_idx_i,
    input  logic [31:0]          wr_data_i,
    input  logic [IW-1:0]        rd_idx_i,
    output logic [31:0]          rd_data_o,
    output logic [NWORDS*32-1:0] words_o
);
    logic [31:0] word_q [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (wr_en_i && (wr_idx_i == IW'(g)))
                word_q[g] <= wr_data_i;
        end
        assign words_o[g*32 +: 32] = word_q[g];
    end

    assign rd_data_o = word_q[rd_idx_i];
endmodule

// File: rtl/m2s_byte_pick.sv
module m2s_byte_pick #(
    parameter int LANES = 4,
    localparam int LW = $clog2(LANES)
) (
    input  logic [LANES*8-1:0] word_i,
    input  logic [LW-1:0]      lane_i,
    output logic [7:0]         byte_o
);
    logic [7:0] lane_b [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = word_i[g*8 +: 8];
    end

    assign byte_o = lane_b[lane_i];
endmodule

// File: rtl/m2s_burst_ctr.sv
module m2s_burst_ctr #(
    parameter int LIMIT = 2048,
    localparam int CW = $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_cap_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (inc_i)
            cnt_q <= cnt_q + CW'(1);
    end

    // high when the byte now being accepted is the LIMIT-th of the burst
    assign at_cap_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/m2s_dma_engine.sv
module m2s_dma_engine
    import m2s_dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BURST_MAX = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] desc_ptr_i,
    input  logic [ADDR_W-1:0] ctx_ptr_i,
    output logic              busy_o,
    output logic              eol_o,
    output logic              irq_set_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              st_valid_o,
    input  logic              st_ready_i,
    output logic [7:0]        st_data_o,
    output logic              st_last_o
);
    localparam int IW    = $clog2(DESC_WORDS);
    localparam int LANES = 4;
    localparam int LW    = $clog2(LANES);

    m2s_state_e state_q, state_d;

    logic [ADDR_W-1:0]      desc_ptr_q, ctx_ptr_q, sbuf_q;
    logic [31:0]            wbuf_q, ctx_word_q;
    logic [IW-1:0]          idx_q;
    logic                   take_buf_q, eol_q;
    logic [DESC_WORDS*32-1:0] words;
    logic [31:0]            wb_word;
    logic                   at_cap;

    logic [ADDR_W-1:0] d_next, d_buf, d_after, eff_buf, nxt_buf;
    logic              f_eol, f_oeop, f_irq, last_word, accept, mem_done;

    assign d_next    = words[W_NEXT*32  +: ADDR_W];
    assign d_buf     = words[W_BUF*32   +: ADDR_W];
    assign d_after   = words[W_AFTER*32 +: ADDR_W];
    assign f_eol     = words[W_FLAGS*32 + FLG_EOL];
    assign f_oeop    = words[W_FLAGS*32 + FLG_OEOP];
    assign f_irq     = words[W_FLAGS*32 + FLG_IRQ];
    assign eff_buf   = take_buf_q ? d_buf : sbuf_q;
    assign nxt_buf   = sbuf_q + ADDR_W'(1);
    assign last_word = (idx_q == IW'(DESC_WORDS - 1));
    assign accept    = (state_q == ST_STREAM) && st_ready_i;
    assign mem_done  = mem_req_o && mem_ack_i;

    m2s_desc_regs #(.NWORDS(DESC_WORDS)) desc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   ((state_q == ST_LOAD) && mem_ack_i),
        .wr_idx_i  (idx_q),
        .wr_data_i (mem_rdata_i),
        .rd_idx_i  (idx_q),
        .rd_data_o (wb_word),
        .words_o   (words)
    );

    m2s_byte_pick #(.LANES(LANES)) pick_i (
        .word_i (wbuf_q),
        .lane_i (sbuf_q[LW-1:0]),
        .byte_o (st_data_o)
    );

    m2s_burst_ctr #(.LIMIT(BURST_MAX)) burst_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (state_q == ST_CHECK),
        .inc_i    (accept),
        .at_cap_o (at_cap)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_LOAD;
            ST_LOAD:   if (mem_ack_i && last_word) state_d = ST_CHECK;
            ST_CHECK:  state_d = (eff_buf == d_after) ? ST_FINISH : ST_FETCH;
            ST_FETCH:  if (mem_ack_i) state_d = ST_STREAM;
            ST_STREAM: begin
                if (st_ready_i) begin
                    if (nxt_buf == d_after)          state_d = ST_FINISH;
                    else if (at_cap)                 state_d = ST_LOAD;
                    else if (nxt_buf[LW-1:0] == '0)  state_d = ST_FETCH;
                end
            end
            ST_FINISH: state_d = ST_WBACK;
            ST_WBACK:  if (mem_ack_i && last_word) state_d = f_eol ? ST_CTX_RD : ST_LOAD;
            ST_CTX_RD: if (mem_ack_i) state_d = ST_CTX_WR;
            ST_CTX_WR: if (mem_ack_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ptr_q <= '0;
            ctx_ptr_q  <= '0;
            sbuf_q     <= '0;
            wbuf_q     <= '0;
            ctx_word_q <= '0;
            idx_q      <= '0;
            take_buf_q <= 1'b0;
            eol_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    desc_ptr_q <= desc_ptr_i;
                    ctx_ptr_q  <= ctx_ptr_i;
                    eol_q      <= 1'b0;
                    take_buf_q <= 1'b1;
                    idx_q      <= '0;
                end
                ST_LOAD:  if (mem_ack_i) idx_q <= idx_q + IW'(1);
                ST_CHECK: begin
                    sbuf_q     <= eff_buf;
                    take_buf_q <= 1'b0;
                end
                ST_FETCH:  if (mem_ack_i) wbuf_q <= mem_rdata_i;
                ST_STREAM: if (st_ready_i) sbuf_q <= nxt_buf;
                ST_FINISH: idx_q <= '0;
                ST_WBACK: if (mem_ack_i) begin
                    idx_q <= idx_q + IW'(1);
                    if (last_word && !f_eol) begin
                        desc_ptr_q <= d_next;
                        take_buf_q <= 1'b1;
                    end
                end
                ST_CTX_RD: if (mem_ack_i) ctx_word_q <= mem_rdata_i;
                ST_CTX_WR: if (mem_ack_i) eol_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        st_valid_o  = 1'b0;
        st_last_o   = 1'b0;
        irq_set_o   = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_ptr_q + (ADDR_W'(idx_q) << 2);
            end
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {sbuf_q[ADDR_W-1:LW], {LW{1'b0}}};
            end
            ST_STREAM: begin
                st_valid_o = 1'b1;
                st_last_o  = f_oeop && (nxt_buf == d_after);
            end
            ST_FINISH: irq_set_o = f_irq;
            ST_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_ptr_q + (ADDR_W'(idx_q) << 2);
                mem_wdata_o = wb_word;
            end
            ST_CTX_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ctx_ptr_q + ADDR_W'(4);
            end
            ST_CTX_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ctx_ptr_q + ADDR_W'(4);
                mem_wdata_o = ctx_word_q | (32'd1 << CTX_DIS);
            end
            default: ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
    assign eol_o  = eol_q;

    // assertions
    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                    && $stable(mem_we_o) && $stable(mem_wdata_o));

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o) && $stable(st_last_o));

    assert_last_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o && st_ready_i && st_last_o |=> !st_valid_o);

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_o |=> !irq_set_o && mem_req_o && mem_we_o);

    assert_eol_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o && !start_i |=> !mem_req_o && !st_valid_o);

    assert_eol_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eol_o) |-> !busy_o);

    assert_no_mem_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_done);
endmodule

// File: tb/m2s_dma_engine_tb_top.sv
module m2s_dma_engine_tb_top;
    localparam int AW = 16;
    localparam int BM = 8;
    localparam int IRQ_EV = 32'h1000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [AW-1:0] desc_ptr_i = '0, ctx_ptr_i = '0;
    logic busy_o, eol_o, irq_set_o;
    logic mem_req_o, mem_we_o, mem_ack_i = 1'b0;
    logic [AW-1:0] mem_addr_o;
    logic [31:0] mem_wdata_o, mem_rdata_i = '0;
    logic st_valid_o, st_ready_i = 1'b1, st_last_o;
    logic [7:0] st_data_o;

    always #5 clk = ~clk;

    m2s_dma_engine #(.ADDR_W(AW), .BURST_MAX(BM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_ptr_i(desc_ptr_i),
        .ctx_ptr_i(ctx_ptr_i), .busy_o(busy_o), .eol_o(eol_o), .irq_set_o(irq_set_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .st_valid_o(st_valid_o), .st_ready_i(st_ready_i), .st_data_o(st_data_o),
        .st_last_o(st_last_o)
    );

    logic [31:0] mem [0:1023];
    bit          is_desc [0:1023];
    bit          is_head [0:1023];
    int checks = 0, errors = 0;
    int evq[$];
    int head_reads, wb_writes, ctx_writes, irq_seen;
    int exp_heads, exp_wb, exp_irq;
    int ctx_addr;
    logic [31:0] ctx_exp;
    bit bp_mode = 0, lat_mode = 0, quiet_watch = 0;
    bit prev_stall = 0;
    logic [8:0] prev_out;
    int wait_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int byte_at(input int a);
        return (mem[a >> 2] >> (8 * (a & 3))) & 8'hFF;
    endfunction

    task automatic put_desc(input int a, input int nxt, input int bstart,
                            input int flags, input int after);
        int len;
        mem[a >> 2] = nxt; mem[(a >> 2) + 1] = bstart;
        mem[(a >> 2) + 2] = flags; mem[(a >> 2) + 3] = after;
        for (int k = 0; k < 4; k++) is_desc[(a >> 2) + k] = 1;
        is_head[a >> 2] = 1;
        for (int b = bstart; b < after; b++)
            evq.push_back(byte_at(b) | (((b == after - 1) && flags[3]) ? 32'h100 : 0));
        if (flags[4]) begin evq.push_back(IRQ_EV); exp_irq++; end
        len = after - bstart;
        exp_heads += (len == 0) ? 1 : (len + BM - 1) / BM;
        exp_wb += 4;
    endtask

    task automatic clear_model(input int ctx);
        evq.delete();
        head_reads = 0; wb_writes = 0; ctx_writes = 0; irq_seen = 0;
        exp_heads = 0; exp_wb = 0; exp_irq = 0;
        for (int i = 0; i < 1024; i++) begin is_desc[i] = 0; is_head[i] = 0; end
        ctx_addr = ctx;
        mem[(ctx + 4) >> 2] = 32'h0000_00A0 ^ ctx;
        ctx_exp = mem[(ctx + 4) >> 2] | 32'h8000;
    endtask

    // memory responder, sink and per-cycle comparison
    initial begin
        forever begin
            @(negedge clk);
            st_ready_i = bp_mode ? (($urandom % 4) != 0) : 1'b1;
            if (mem_ack_i) begin
                mem_ack_i = 1'b0;
            end else if (mem_req_o && rst_n) begin
                if (wait_cnt > 0) wait_cnt--;
                else begin
                    int w;
                    w = int'(mem_addr_o) >> 2;
                    mem_ack_i = 1'b1;
                    if (mem_we_o) begin
                        if (int'(mem_addr_o) == ctx_addr + 4) begin
                            chk(evq.size() == 0, "R11 ctx write after all bytes", evq.size(), 0);
                            chk(mem_wdata_o == ctx_exp, "R11 ctx disable bit", mem_wdata_o, ctx_exp);
                            ctx_writes++;
                        end else begin
                            chk(is_desc[w] && mem_wdata_o == mem[w], "R9 writeback", mem_wdata_o, mem[w]);
                            wb_writes++;
                        end
                        mem[w] = mem_wdata_o;
                    end else begin
                        mem_rdata_i = mem[w];
                        if (is_head[w]) head_reads++;
                    end
                    wait_cnt = lat_mode ? int'($urandom % 3) : 0;
                end
            end
            #1;
            if (prev_stall)
                chk(st_valid_o && {st_last_o, st_data_o} == prev_out, "R4 stall hold",
                    {st_last_o, st_data_o}, prev_out);
            prev_stall = st_valid_o && !st_ready_i;
            prev_out = {st_last_o, st_data_o};
            if (st_valid_o && st_ready_i) begin
                int e;
                e = (evq.size() > 0) ? evq.pop_front() : -1;
                chk(e == int'({st_last_o, st_data_o}), "R3/R5 stream byte",
                    {st_last_o, st_data_o}, e);
            end
            if (irq_set_o) begin
                int e;
                irq_seen++;
                e = (evq.size() > 0) ? evq.pop_front() : -1;
                chk(e == IRQ_EV, "R8 interrupt order", IRQ_EV, e);
            end
            if (quiet_watch)
                chk(!mem_req_o && !st_valid_o, "R12 quiet at end of list",
                    {mem_req_o, st_valid_o}, 0);
        end
    end

    task automatic start_run(input int dp, input int cp);
        @(negedge clk);
        start_i = 1'b1; desc_ptr_i = AW'(dp); ctx_ptr_i = AW'(cp);
        @(negedge clk);
        start_i = 1'b0;
        #2;
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        chk(eol_o == 1'b0, "R2 eol cleared by start", eol_o, 0);
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!eol_o && n < 20000) begin @(negedge clk); n++; end
        chk(n < 20000, "watchdog", n, 20000);
        #2;
        chk(!busy_o, "R11 idle at end", busy_o, 0);
        chk(evq.size() == 0, "R3/R10 all events seen", evq.size(), 0);
        chk(wb_writes == exp_wb, "R9 writeback count", wb_writes, exp_wb);
        chk(ctx_writes == 1, "R11 one ctx write", ctx_writes, 1);
        chk(head_reads == exp_heads, "R7 descriptor reads", head_reads, exp_heads);
        chk(irq_seen == exp_irq, "R6/R8 interrupt count", irq_seen, exp_irq);
        quiet_watch = 1;
        repeat (20) @(negedge clk);
        quiet_watch = 0;
        $display("run %s done", tag);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h0103_0507) ^ 32'hA5C3_0F11;
        repeat (3) @(negedge clk);
        #2;
        chk(!busy_o && !eol_o && !irq_set_o && !st_valid_o && !mem_req_o, "R1 reset state",
            {busy_o, eol_o, irq_set_o, st_valid_o, mem_req_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // run 1: single unaligned descriptor, eol+eop+irq
        clear_model(32'h020);
        put_desc(32'h040, 0, 32'h103, 32'h19, 32'h108);
        start_run(32'h040, 32'h020);
        wait_done("single");

        // run 2: chain with reloads, empty descriptor, backpressure, latency
        bp_mode = 1; lat_mode = 1;
        clear_model(32'h3C0);
        put_desc(32'h300, 32'h340, 32'h401, 32'h10, 32'h415);   // R7 len 20
        put_desc(32'h340, 32'h380, 32'h500, 32'h10, 32'h500);   // R6 empty
        put_desc(32'h380, 0, 32'h602, 32'h09, 32'h605);         // R10 last in chain
        start_run(32'h300, 32'h3C0);
        repeat (15) @(negedge clk);
        start_i = 1'b1; desc_ptr_i = AW'(32'h040);              // R2 ignored while busy
        @(negedge clk);
        start_i = 1'b0;
        wait_done("chain");

        // run 3: length equal to cap, no eop, no irq
        bp_mode = 0;
        clear_model(32'h780);
        put_desc(32'h700, 0, 32'h800, 32'h01, 32'h808);
        start_run(32'h700, 32'h780);
        wait_done("cap");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule